// File: doc/BRIEF.md
# Temperature-Derated Capacity Scaler

This block turns a nominal available-charge count into the capacity figure that a battery gauge should report. In the cold a cell delivers less of its stored charge. The reported figure is therefore reduced by a factor that depends on a temperature band. There are three bands:

- **Warm:** no reduction.
- **Middle:** three quarters of the count.
- **Cold:** half of the count.

The boundary between warm and middle has 4 °C of hysteresis, so a reading that sits near freezing does not make the display flicker. The boundary into the cold band is a plain strict comparison.

A producer presents three values together with a one-cycle valid strobe:

- a signed temperature in whole degrees Celsius;
- the nominal charge count;
- the full-capacity reference.

One cycle later the block presents the derated capacity, together with the full reference captured on the same strobe. A downstream stage can then form a percentage or a segment count from a coherent pair. The scaling uses only shifts and one adder, and every result truncates toward zero.

Top module: `capscale_top`

## Requirements
- R1: After a synchronous reset, `cap_vld` is 0, `cap_out` is 0, `full_ref_out` is 0, and the hysteresis state is warm. A first sample at a temperature from 0 to 4 °C is therefore reported unscaled.
- R2: While the band is warm, a strobed sample yields `cap_out` equal to `nac_in`.
- R3: While the band is middle, a strobed sample yields `cap_out` = (`nac_in`>>1)+(`nac_in`>>2), truncated.
- R4: When the hysteresis state is not warm and the temperature is strictly below -20 °C, `cap_out` = `nac_in`>>1. Exactly -20 °C gives the middle-band result.
- R5: The state leaves warm only on a sample whose temperature is below 0 °C. A sample at exactly 0 °C keeps it warm.
- R6: The state returns to warm only on a sample whose temperature is above +4 °C. Samples from 0 to +4 °C keep it out of warm. The band chosen for a sample already reflects that sample's own transition.
- R7: Outputs change only in the cycle after a strobe. `cap_vld` is high exactly in the cycle after each strobe. Without a strobe, `cap_out`, `full_ref_out` and the band state hold whatever the inputs do.
- R8: `full_ref_out` equals the `full_ref_in` value sampled on the same strobe as the `cap_out` it accompanies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| temp_c | input | TEMP_W (8) | Signed temperature in °C |
| nac_in | input | CHG_W (16) | Nominal available charge count |
| full_ref_in | input | CHG_W (16) | Full-capacity reference |
| cap_vld | output | 1 | Result valid, one cycle after the strobe |
| cap_out | output | CHG_W (16) | Derated available capacity |
| full_ref_out | output | CHG_W (16) | Full reference paired with cap_out |

## Verification
Temperature is swept downward in single steps through 0 °C and past -20 °C. It is then swept upward through the 0 to +4 °C dead zone, and finally moved in large jumps from one extreme to the other. These sweeps separate a correct hysteresis from a plain threshold at either edge, and a strict cold comparison from an inclusive one.

The charge counts are zero, all ones, and small odd values such as 1, 3 and 7. These show whether the three-quarter path truncates each shifted term, and whether any path overflows.

Idle gaps change every input without a strobe, which shows that neither the outputs nor the band state move. A reset applied while the state sits in the middle band shows that the state returns to warm.

// File: rtl/capscale_pkg.sv
package capscale_pkg;

    typedef enum logic [1:0] {
        BAND_WARM = 2'd0,
        BAND_MID  = 2'd1,
        BAND_COLD = 2'd2
    } band_t;

    localparam int DEF_TEMP_W      = 8;
    localparam int DEF_CHG_W       = 16;
    localparam int DEF_WARM_EXIT   = 0;
    localparam int DEF_WARM_ENTER  = 4;
    localparam int DEF_COLD_LIMIT  = -20;

    typedef struct packed {
        logic [1:0] shift_a;  // first shift amount
        logic [1:0] shift_b;  // second shift amount
        logic       use_b;    // add the second term
        logic       pass;     // pass through unscaled
    } scale_plan_t;

    function automatic scale_plan_t plan_for(band_t b);
        scale_plan_t p;
        p = '{shift_a: 2'd1, shift_b: 2'd2, use_b: 1'b0, pass: 1'b0};
        unique case (b)
            BAND_WARM: p.pass  = 1'b1;
            BAND_MID:  p.use_b = 1'b1;
            default:   p.use_b = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/capscale_band_fsm.sv
module capscale_band_fsm
    import capscale_pkg::*;
#(
    parameter int TEMP_W     = DEF_TEMP_W,
    parameter int WARM_EXIT  = DEF_WARM_EXIT,
    parameter int WARM_ENTER = DEF_WARM_ENTER,
    parameter int COLD_LIMIT = DEF_COLD_LIMIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld,
    input  logic signed [TEMP_W-1:0] temp_c,
    output band_t                    band,
    output logic                     warm_q
);

    logic warm_nxt;
    logic below_exit, above_enter, below_cold;

    assign below_exit  = (int'(temp_c) < WARM_EXIT);
    assign above_enter = (int'(temp_c) > WARM_ENTER);
    assign below_cold  = (int'(temp_c) < COLD_LIMIT);

    always_comb begin
        warm_nxt = warm_q;
        if (smp_vld) begin
            if (warm_q && below_exit)
                warm_nxt = 1'b0;
            else if (!warm_q && above_enter)
                warm_nxt = 1'b1;
        end
    end

    always_comb begin
        if (warm_nxt)
            band = BAND_WARM;
        else if (below_cold)
            band = BAND_COLD;
        else
            band = BAND_MID;
    end

    always_ff @(posedge clk) begin
        if (rst)
            warm_q <= 1'b1;
        else
            warm_q <= warm_nxt;
    end

    // R5: leave warm only below the exit threshold
    a_r5_stay_warm: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && warm_q && int'(temp_c) >= WARM_EXIT) |=> warm_q);
    a_r5_leave_warm: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && warm_q && int'(temp_c) < WARM_EXIT) |=> !warm_q);
    // R6: return to warm only above the entry threshold
    a_r6_stay_cool: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !warm_q && int'(temp_c) <= WARM_ENTER) |=> !warm_q);
    a_r6_return_warm: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !warm_q && int'(temp_c) > WARM_ENTER) |=> warm_q);
    // R7: state ignores idle cycles
    a_r7_state_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(warm_q));

endmodule

// File: rtl/capscale_derate.sv
module capscale_derate
    import capscale_pkg::*;
#(
    parameter int CHG_W = DEF_CHG_W
) (
    input  band_t             band,
    input  logic [CHG_W-1:0]  nac,
    output logic [CHG_W-1:0]  scaled
);

    scale_plan_t      plan;
    logic [CHG_W-1:0] term_a, term_b;

    assign plan   = plan_for(band);
    assign term_a = nac >> plan.shift_a;
    assign term_b = plan.use_b ? (nac >> plan.shift_b) : '0;

    always_comb begin
        if (plan.pass)
            scaled = nac;
        else
            scaled = term_a + term_b;
    end

    // R3: shift-add result never exceeds its input
    always_comb begin
        a_r3_no_growth: assert (scaled <= nac);
    end

endmodule

// File: rtl/capscale_top.sv
module capscale_top
    import capscale_pkg::*;
#(
    parameter int TEMP_W     = DEF_TEMP_W,
    parameter int CHG_W      = DEF_CHG_W,
    parameter int WARM_EXIT  = DEF_WARM_EXIT,
    parameter int WARM_ENTER = DEF_WARM_ENTER,
    parameter int COLD_LIMIT = DEF_COLD_LIMIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld,
    input  logic signed [TEMP_W-1:0] temp_c,
    input  logic [CHG_W-1:0]         nac_in,
    input  logic [CHG_W-1:0]         full_ref_in,
    output logic                     cap_vld,
    output logic [CHG_W-1:0]         cap_out,
    output logic [CHG_W-1:0]         full_ref_out
);

    band_t            band;
    logic             warm_q;
    logic [CHG_W-1:0] scaled;

    capscale_band_fsm #(
        .TEMP_W     (TEMP_W),
        .WARM_EXIT  (WARM_EXIT),
        .WARM_ENTER (WARM_ENTER),
        .COLD_LIMIT (COLD_LIMIT)
    ) u_band (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .temp_c  (temp_c),
        .band    (band),
        .warm_q  (warm_q)
    );

    capscale_derate #(
        .CHG_W (CHG_W)
    ) u_derate (
        .band   (band),
        .nac    (nac_in),
        .scaled (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld      <= 1'b0;
            cap_out      <= '0;
            full_ref_out <= '0;
        end else begin
            cap_vld <= smp_vld;
            if (smp_vld) begin
                cap_out      <= scaled;
                full_ref_out <= full_ref_in;
            end
        end
    end

    // R7: valid strictly follows the strobe, outputs hold when idle
    a_r7_vld_on: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> cap_vld);
    a_r7_vld_off: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !cap_vld);
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(cap_out) && $stable(full_ref_out)));
    // R2: warm band passes the count through
    a_r2_warm_pass: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && band == BAND_WARM) |=> cap_out == $past(nac_in));
    // R4: below the cold limit with state not warm, output is half
    a_r4_cold_half: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !warm_q && int'(temp_c) < COLD_LIMIT)
        |=> cap_out == ($past(nac_in) >> 1));
    // R8: reference travels with its sample
    a_r8_ref_pair: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> full_ref_out == $past(full_ref_in));

endmodule

// File: tb/capscale_top_tb.sv
module capscale_top_tb;

    localparam int TEMP_W = 8;
    localparam int CHG_W  = 16;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     smp_vld = 1'b0;
    logic signed [TEMP_W-1:0] temp_c = '0;
    logic [CHG_W-1:0]         nac_in = '0;
    logic [CHG_W-1:0]         full_ref_in = '0;
    logic                     cap_vld;
    logic [CHG_W-1:0]         cap_out;
    logic [CHG_W-1:0]         full_ref_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    bit m_warm = 1'b1;
    int m_out = 0;
    int m_ref = 0;
    bit m_vld = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    capscale_top #(.TEMP_W(TEMP_W), .CHG_W(CHG_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .smp_vld      (smp_vld),
        .temp_c       (temp_c),
        .nac_in       (nac_in),
        .full_ref_in  (full_ref_in),
        .cap_vld      (cap_vld),
        .cap_out      (cap_out),
        .full_ref_out (full_ref_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " vld"}, int'(cap_vld), int'(m_vld));
        check({tag, " cap"}, int'(cap_out), m_out);
        check("R8 ref", int'(full_ref_out), m_ref);
    endtask

    // one clock: drive after a falling edge, compare at the next falling edge
    task automatic step(input bit v, input int t, input int n, input int f);
        string tag;
        bit prev;
        smp_vld     = v;
        temp_c      = TEMP_W'(t);
        nac_in      = CHG_W'(n);
        full_ref_in = CHG_W'(f);
        if (v) begin
            prev = m_warm;
            if (m_warm && t < 0) m_warm = 1'b0;
            else if (!m_warm && t > 4) m_warm = 1'b1;
            if (m_warm) begin m_out = n; tag = "R2"; end
            else if (t < -20) begin m_out = n / 2; tag = "R4"; end
            else begin m_out = n / 2 + n / 4; tag = "R3"; end
            if (t >= 0 && t <= 4) tag = prev ? "R5" : "R6";
            m_ref = f;
            m_vld = 1'b1;
        end else begin
            m_vld = 1'b0;
            tag = "R7";
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_warm = 1'b1; m_out = 0; m_ref = 0; m_vld = 1'b0;
        compare("R1");
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: first sample at 2 degC reported unscaled
        step(1, 2, 1000, 4000);
        // R2: warm passes through, extremes of count
        step(1, 25, 65535, 65535);
        step(1, 127, 0, 1);
        step(1, 1, 7, 9);
        // R5: 0 keeps warm, -1 leaves
        step(1, 0, 401, 500);
        step(1, -1, 401, 500);
        step(1, -1, 3, 10);
        step(1, -1, 65535, 10);
        // R4: boundary -20 is middle, -21 is cold
        step(1, -20, 7, 11);
        step(1, -21, 7, 11);
        step(1, -21, 65535, 12);
        step(1, -128, 1, 13);
        // R7: idle with changing inputs
        step(0, 50, 1234, 999);
        step(0, -128, 4321, 1);
        // R6: rising through dead zone
        step(1, -5, 800, 20);
        for (int t = 0; t <= 4; t++) step(1, t, 1001 + t, 30 + t);
        step(0, 100, 5, 5);
        step(1, 5, 1001, 40);
        step(1, 2, 1001, 41);
        // large jumps
        step(1, -100, 999, 50);
        step(1, 100, 999, 51);
        step(1, -100, 3, 52);
        // back-to-back with gaps
        for (int i = 0; i < 20; i++) step(i % 3 != 0, (i * 37) % 60 - 30, i * 3313, i);
        // R1: reset while middle returns to warm
        step(1, -10, 2000, 60);
        do_reset();
        step(1, 3, 2000, 61);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule